// File: doc/BRIEF.md
# Time-Triggered Cycle Counter and Transmit Window

This block supports time-triggered message scheduling on a CAN-style controller. It tracks which basic cycle of a repeating matrix cycle is running. After each scheduled time mark it opens a transmit-enable window, and while that window is open a transmission may begin. The block does not handle bit timing, arbitration, frame transmission or message storage. It only decides when a transmission is allowed to start.

A 16-bit configuration word holds two codes. The first is a 3-bit cycle-limit code at bits 10..8. The second is a 4-bit window-width code at bits 3..0. The cycle-limit code also selects the operating mode. The all-ones code (the reset value) selects event-triggered operation, which holds the counter at zero and keeps the window closed. Every other code selects time-triggered operation, where the counter steps on basic-cycle-start pulses and a time-mark pulse opens a window measured in nominal bit times.

Top module: `tt_cycle_window`

## Requirements
- R1: After reset, `cycleCount` is 0, `ttMode` is 0, `txWindow` is 0 and `cfgRdata` reads 16'h0700 (limit code 7, width code 0).
- R2: In time-triggered mode the counter wraps to 0 on the pulse after it reaches the cycle maximum. The maximum is 0 for limit code 0 and (2^code − 1) for codes 1 through 6.
- R3: In time-triggered mode each `cycleStart` pulse that is not a wrap raises `cycleCount` by one in the next cycle. The count stays unchanged while no pulse and no configuration write occur.
- R4: In event-triggered mode (limit code 7), `cycleCount` stays 0 and `txWindow` stays 0, whatever `cycleStart`, `markHit` and `bitTick` do. A write that selects code 7 closes an open window from the next cycle on.
- R5: `ttMode` is 1 exactly when the stored limit code differs from 7.
- R6: In time-triggered mode a `markHit` opens `txWindow` in the next cycle. The window then stays open for exactly (width code + 1) `bitTick` pulses and closes after the last one. Cycles without a tick do not shorten it.
- R7: A `markHit` while the window is open restarts the full (width code + 1) tick duration.
- R8: `cfgRdata` returns the two stored codes at bits 10..8 and 3..0. All other bits (15..11 and 7..4) read as 0, whatever was written to them.
- R9: Any configuration write sets `cycleCount` to 0 in the next cycle, even when a `cycleStart` arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write data |
| cfgRdata | output | 16 | Configuration readback |
| bitTick | input | 1 | One pulse per nominal bit time |
| cycleStart | input | 1 | Basic-cycle-start pulse |
| markHit | input | 1 | Time-mark match pulse |
| cycleCount | output | 6 | Current basic-cycle number |
| ttMode | output | 1 | 1 for time-triggered, 0 for event-triggered |
| txWindow | output | 1 | Transmit-enable window |

## Verification
The hardest state to reach from the ports is the wrap at the largest limit code. It needs 63 start pulses before the count shows 63, and a 64th pulse before the wrap appears, so the vector table drives runs of 63 and 70 pulses at code 6. The window restart and the write-to-event close both need the window to be open partway through its duration. Directed tests therefore open it, give only part of its ticks, and then apply the second mark or the mode write before checking the remaining duration.

// File: rtl/tt_window_pkg.sv
package tt_window_pkg;

  // Strobes from control to datapath, evaluated once per clock.
  typedef struct packed {
    logic cntClr;   // force cycle counter to zero
    logic cntInc;   // step cycle counter
    logic cntWrap;  // step lands on zero (counter at limit)
    logic winClr;   // close window immediately
    logic winLoad;  // (re)open window with full width
    logic winDec;   // consume one bit time of the window
  } dpStrobes_t;

endpackage

// File: rtl/tt_window_ctrl.sv
module tt_window_ctrl
  import tt_window_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int MAXC_W   = 3,
  parameter int MAXC_LSB = 8,
  parameter int WIN_W    = 4,
  parameter int CNT_W    = (1 << MAXC_W) - 2,
  parameter int REM_W    = WIN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             cycleStart,
  input  logic             markHit,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             winActive,
  output dpStrobes_t       strb,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             ttMode,
  output logic [REM_W-1:0] winLoadVal
);

  localparam int EVT_CODE = (1 << MAXC_W) - 1;

  logic [MAXC_W-1:0] maxCode;
  logic [WIN_W-1:0]  winCode;
  logic [CNT_W-1:0]  cycleMax;
  logic              newIsEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxCode <= '1;
      winCode <= '0;
    end else if (cfgWe) begin
      maxCode <= cfgWdata[MAXC_LSB +: MAXC_W];
      winCode <= cfgWdata[0 +: WIN_W];
    end
  end

  assign ttMode     = (maxCode != MAXC_W'(EVT_CODE));
  assign newIsEvent = (cfgWdata[MAXC_LSB +: MAXC_W] == MAXC_W'(EVT_CODE));

  // Limit decode: code 0 -> 0, code n -> 2^n - 1.
  always_comb begin
    cycleMax = '0;
    for (int i = 1; i < EVT_CODE; i++) begin
      if (maxCode == MAXC_W'(i)) cycleMax = CNT_W'((64'd1 << i) - 64'd1);
    end
  end

  always_comb begin
    strb.cntClr  = cfgWe || !ttMode;
    strb.cntInc  = ttMode && cycleStart && !cfgWe;
    strb.cntWrap = ttMode && cycleStart && !cfgWe && (cycleCount == cycleMax);
    strb.winClr  = !ttMode || (cfgWe && newIsEvent);
    strb.winLoad = ttMode && markHit && !(cfgWe && newIsEvent);
    strb.winDec  = bitTick && winActive;
  end

  assign winLoadVal = REM_W'(winCode) + REM_W'(1);

  always_comb begin
    cfgRdata = '0;
    cfgRdata[MAXC_LSB +: MAXC_W] = maxCode;
    cfgRdata[0 +: WIN_W]         = winCode;
  end

endmodule

// File: rtl/tt_window_dp.sv
module tt_window_dp
  import tt_window_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int REM_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic [REM_W-1:0] winLoadVal,
  output logic [CNT_W-1:0] cycleCount,
  output logic             winActive
);

  logic [REM_W-1:0] winRemain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCount <= '0;
    end else if (strb.cntClr || strb.cntWrap) begin
      cycleCount <= '0;
    end else if (strb.cntInc) begin
      cycleCount <= cycleCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winRemain <= '0;
    end else if (strb.winClr) begin
      winRemain <= '0;
    end else if (strb.winLoad) begin
      winRemain <= winLoadVal;
    end else if (strb.winDec) begin
      winRemain <= winRemain - REM_W'(1);
    end
  end

  assign winActive = (winRemain != '0);

endmodule

// File: rtl/tt_cycle_window.sv
module tt_cycle_window
  import tt_window_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int MAXC_W   = 3,
  parameter int MAXC_LSB = 8,
  parameter int WIN_W    = 4,
  localparam int CNT_W   = (1 << MAXC_W) - 2,
  localparam int REM_W   = WIN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             bitTick,
  input  logic             cycleStart,
  input  logic             markHit,
  output logic [CNT_W-1:0] cycleCount,
  output logic             ttMode,
  output logic             txWindow
);

  dpStrobes_t       strb;
  logic [REM_W-1:0] winLoadVal;
  logic             winActive;

  tt_window_ctrl #(
    .CFG_W(CFG_W), .MAXC_W(MAXC_W), .MAXC_LSB(MAXC_LSB),
    .WIN_W(WIN_W), .CNT_W(CNT_W), .REM_W(REM_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cycleStart(cycleStart), .markHit(markHit), .bitTick(bitTick),
    .cycleCount(cycleCount), .winActive(winActive), .strb(strb),
    .cfgRdata(cfgRdata), .ttMode(ttMode), .winLoadVal(winLoadVal)
  );

  tt_window_dp #(.CNT_W(CNT_W), .REM_W(REM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .winLoadVal(winLoadVal),
    .cycleCount(cycleCount), .winActive(winActive)
  );

  assign txWindow = winActive;

endmodule

// File: rtl/tt_cycle_window_chk.sv
module tt_cycle_window_chk #(
  parameter int CFG_W    = 16,
  parameter int MAXC_W   = 3,
  parameter int MAXC_LSB = 8,
  parameter int WIN_W    = 4,
  parameter int CNT_W    = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [CFG_W-1:0] cfgRdata,
  input logic             cycleStart,
  input logic             markHit,
  input logic [CNT_W-1:0] cycleCount,
  input logic             ttMode,
  input logic             txWindow
);

  localparam int EVT_CODE = (1 << MAXC_W) - 1;

  logic [MAXC_W-1:0] code;
  int                limitVal;
  assign code     = cfgRdata[MAXC_LSB +: MAXC_W];
  assign limitVal = (code == 0) ? 0 : ((1 << code) - 1);

  // R5: mode flag follows stored code
  p_mode_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    ttMode == (code != MAXC_W'(EVT_CODE)));

  // R4: event mode keeps counter and window idle
  p_event_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ttMode |-> (cycleCount == '0 && !txWindow));

  // R2: counter never exceeds limit
  p_count_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ttMode |-> (int'(cycleCount) <= limitVal));

  // R2: wrap at the limit
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ttMode && cycleStart && !cfgWe && int'(cycleCount) == limitVal)
      |=> cycleCount == '0);

  // R3: single step
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ttMode && cycleStart && !cfgWe && int'(cycleCount) != limitVal)
      |=> cycleCount == $past(cycleCount) + CNT_W'(1));

  // R3: hold without pulse
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleStart && !cfgWe) |=> $stable(cycleCount));

  // R9: write clears counter
  p_wr_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cycleCount == '0);

  // R6: mark opens window
  p_mark_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ttMode && markHit && !cfgWe) |=> txWindow);

  // R8: unused readback bits are zero
  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~((CFG_W'((1 << MAXC_W) - 1) << MAXC_LSB) | CFG_W'((1 << WIN_W) - 1)))
      == '0);

endmodule

bind tt_cycle_window tt_cycle_window_chk #(
  .CFG_W(CFG_W), .MAXC_W(MAXC_W), .MAXC_LSB(MAXC_LSB), .WIN_W(WIN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRdata(cfgRdata),
  .cycleStart(cycleStart), .markHit(markHit), .cycleCount(cycleCount),
  .ttMode(ttMode), .txWindow(txWindow)
);

// File: tb/tt_cycle_window_test.sv
`timescale 1ns/1ps
module tt_cycle_window_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        bitTick = 1'b0;
  logic        cycleStart = 1'b0;
  logic        markHit = 1'b0;
  logic [5:0]  cycleCount;
  logic        ttMode;
  logic        txWindow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tt_cycle_window uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .bitTick(bitTick), .cycleStart(cycleStart),
    .markHit(markHit), .cycleCount(cycleCount), .ttMode(ttMode),
    .txWindow(txWindow)
  );

  typedef struct packed {
    logic [2:0] limCode;
    logic [3:0] winCode;
    logic [7:0] starts;
    logic [5:0] expCount;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 4'd0,  8'd3,  6'd0},
    '{3'd1, 4'd1,  8'd3,  6'd1},
    '{3'd2, 4'd2,  8'd5,  6'd1},
    '{3'd3, 4'd15, 8'd9,  6'd1},
    '{3'd4, 4'd3,  8'd20, 6'd4},
    '{3'd5, 4'd7,  8'd33, 6'd1},
    '{3'd6, 4'd4,  8'd70, 6'd6},
    '{3'd6, 4'd0,  8'd63, 6'd63},
    '{3'd7, 4'd5,  8'd6,  6'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(input logic [15:0] d);
    cfgWe = 1'b1; cfgWdata = d;
    step();
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic pulseStart();
    cycleStart = 1'b1; step(); cycleStart = 1'b0;
  endtask

  task automatic pulseMark();
    markHit = 1'b1; step(); markHit = 1'b0;
  endtask

  task automatic pulseTick();
    bitTick = 1'b1; step(); bitTick = 1'b0;
  endtask

  function automatic logic [15:0] cfgWord(input logic [2:0] l, input logic [3:0] w);
    return {5'b0, l, 4'b0, w};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();

    // R1 reset state
    chk("R1 count", cycleCount, 0);
    chk("R1 mode", ttMode, 0);
    chk("R1 window", txWindow, 0);
    chk("R1 readback", cfgRdata, 16'h0700);

    // Vector table: limit decode, counting, window width
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic bit tt = (v.limCode != 3'd7);
      pulseStart();
      writeCfg(cfgWord(v.limCode, v.winCode));
      chk("R9 clear on write", cycleCount, 0);
      chk("R5 mode", ttMode, tt);
      for (int n = 0; n < int'(v.starts); n++) pulseStart();
      chk("R2 R3 count after starts", cycleCount, v.expCount);
      step();
      chk("R3 hold", cycleCount, v.expCount);
      pulseMark();
      for (int k = 0; k <= int'(v.winCode); k++) begin
        chk("R6 R4 window open", txWindow, tt);
        step();
        chk("R6 no tick keeps window", txWindow, tt);
        pulseTick();
      end
      chk("R6 window closed", txWindow, 0);
      if (!tt) chk("R4 count held", cycleCount, 0);
    end

    // R8 readback masks unused bits
    writeCfg(16'hFFFF);
    chk("R8 all ones", cfgRdata, 16'h070F);
    writeCfg(16'hF0F5);
    chk("R8 mixed", cfgRdata, 16'h0005);
    chk("R5 code 0 mode", ttMode, 1);

    // R7 restart during open window
    writeCfg(cfgWord(3'd3, 4'd3));
    pulseMark();
    pulseTick(); pulseTick();
    chk("R7 still open", txWindow, 1);
    pulseMark();
    pulseTick(); pulseTick(); pulseTick();
    chk("R7 restarted duration", txWindow, 1);
    pulseTick();
    chk("R7 closes after full width", txWindow, 0);

    // R9 write mid-count, with simultaneous start pulse
    for (int n = 0; n < 5; n++) pulseStart();
    chk("R3 count five", cycleCount, 5);
    cycleStart = 1'b1;
    writeCfg(cfgWord(3'd3, 4'd3));
    cycleStart = 1'b0;
    chk("R9 write beats start", cycleCount, 0);

    // R4 switching to event mode closes open window
    pulseMark();
    chk("R6 opened", txWindow, 1);
    writeCfg(cfgWord(3'd7, 4'd3));
    chk("R4 window closed by mode write", txWindow, 0);
    chk("R4 mode event", ttMode, 0);
    pulseMark();
    pulseStart();
    chk("R4 mark ignored", txWindow, 0);
    chk("R4 start ignored", cycleCount, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule